// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block snapshots a free-running counter at the moment a chosen transition occurs on an external capture pin. The pin is brought into the system clock domain by a chain of synchronising flops. The two newest synchronised samples are compared to find rising and falling transitions. A two-bit mode field picks which transitions count: falling only, rising only, or both. When a qualifying transition is seen, the counter value is copied into a capture register and a sticky capture flag is set.

Software reaches the block through a small register port with two locations. Location 0 holds the capture value and can only be read. Location 1 holds the mode bits and the flag. Read data is registered. A read that lands in the same cycle as a capture therefore returns the value from before that capture. A standby input clears the capture register while the rest of the state is kept.

Top module: `icap_unit`

## Requirements
- R1: After reset the capture register reads 0x0000, and the control word at address 1 reads 0x0000: mode bits 0 and flag 0.
- R2: With control bit 0 = 0 and bit 1 = 0, only a high-to-low pin transition causes a capture. A low-to-high transition leaves the capture value and the flag unchanged.
- R3: With control bit 0 = 1, only low-to-high transitions capture, whatever the value of bit 1. A high-to-low transition leaves the capture value and the flag unchanged.
- R4: With control bit 0 = 0 and bit 1 = 1, both transition directions capture.
- R5: If the pin changes between rising clock edges k-1 and k, the capture register loads at edge k+2 with the counter value present at that edge. The flag (cap_flag_o and control bit 2) becomes 1 at the same edge and is still 0 before it.
- R6: The flag is sticky. Writing address 1 with bit 2 = 0 clears it. Writing bit 2 = 1 leaves it as it was. A capture in the same cycle as a clear wins.
- R7: A read request (bus_sel_i=1, bus_wr_i=0) sampled at edge m puts data on bus_rdata_o after edge m. If a capture occurs at edge m, the read returns the previous capture value.
- R8: Asserting standby_i for one cycle clears the capture register to 0x0000 at the next edge.
- R9: In single-edge modes a pin pulse two clock periods wide is captured. In the both-edges mode a pulse three periods wide produces two captures, on its leading and its trailing transitions.
- R10: The control word reads back as bit 0 = rise select, bit 1 = both select, bit 2 = flag, and all other bits 0. A write to address 1 loads bits 1:0 from the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Clears the capture register while high |
| cnt_i | input | 16 | Free-running counter value to be captured |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| bus_sel_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address (0 capture, 1 control) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| cap_flag_o | output | 1 | Sticky capture flag |

## Verification
A pin change made at a falling clock edge reaches the capture register at the third rising edge after it. The bench therefore expects the counter value three increments on from the one it saw at the change. It also checks the flag at the second and third falling edges afterwards, so that one cycle of early or late capture is caught. Read data is due one edge after the request. A monitor compares only those read results that a sampled request announces, against a queue the driver filled in request order. The collision case issues its read at the exact falling edge whose following rising edge is the capture edge.

// File: rtl/icap_pkg.sv
// Shared types and register layout for the input capture unit.
// Assumes a two-location register space: capture value and control.
package icap_pkg;

    // Which pin transitions are treated as capture events.
    typedef enum logic [1:0] {
        EDGE_FALL = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_kind_t;

    // Control word bit positions (software-visible layout).
    localparam int unsigned CTRL_RISE_BIT = 0;
    localparam int unsigned CTRL_BOTH_BIT = 1;
    localparam int unsigned CTRL_FLAG_BIT = 2;

    // Register addresses.
    localparam int unsigned ADDR_CAP  = 0;
    localparam int unsigned ADDR_CTRL = 1;

    // Rise select dominates; both select applies only when rise select is clear.
    function automatic edge_kind_t decode_sel(input logic rise_sel, input logic both_sel);
        if (rise_sel)      return EDGE_RISE;
        else if (both_sel) return EDGE_BOTH;
        else               return EDGE_FALL;
    endfunction

endpackage

// File: rtl/icap_sync.sv
// Pin synchroniser: a chain of STAGES flops brings the asynchronous pin
// into the clock domain, and one more flop keeps the previous sample.
// Assumes the pin idles low at reset (all stages reset to 0).
module icap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic cur_o,
    output logic prev_o
);
    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] chain_q;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < LEN; gi++) begin : g_stage
            // Each later stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    assign cur_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/icap_edge_sel.sv
// Edge qualifier: compares the newest and previous synchronised samples
// and flags a capture event for the transition kinds the mode selects.
// Purely combinational; assumes both inputs come from the same clock domain.
module icap_edge_sel
    import icap_pkg::*;
(
    input  logic       cur_i,
    input  logic       prev_i,
    input  edge_kind_t kind_i,
    output logic       hit_o
);
    logic went_up;
    logic went_down;

    // Detect transitions and qualify them by the selected mode.
    always_comb begin
        went_up   = cur_i & ~prev_i;
        went_down = ~cur_i & prev_i;
        unique case (kind_i)
            EDGE_RISE: hit_o = went_up;
            EDGE_BOTH: hit_o = went_up | went_down;
            EDGE_FALL: hit_o = went_down;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_regs.sv
// Register file: capture register, mode bits, sticky flag and a registered
// read port. Assumes one access per cycle and DATA_W of at least 3 bits.
module icap_regs
    import icap_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              hit_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [CNT_W-1:0]  cap_o,
    output logic              rise_sel_o,
    output logic              both_sel_o,
    output logic              flag_o
);
    localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(ADDR_CAP);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] rdata_q;
    logic [CNT_W-1:0] ctrl_word;
    logic             rise_q;
    logic             both_q;
    logic             flag_q;
    logic             wr_ctrl;
    logic             rd_req;

    // Decode the access kinds.
    always_comb begin
        wr_ctrl = sel_i & wr_i & (addr_i == A_CTRL);
        rd_req  = sel_i & ~wr_i;
    end

    // Assemble the control word seen by software.
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_RISE_BIT] = rise_q;
        ctrl_word[CTRL_BOTH_BIT] = both_q;
        ctrl_word[CTRL_FLAG_BIT] = flag_q;
    end

    // Capture register: standby clear first, then capture on a qualified event.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_q <= '0;
        else if (standby_i) cap_q <= '0;
        else if (hit_i)     cap_q <= cnt_i;
    end

    // Mode bits: loaded by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            both_q <= 1'b0;
        end else if (wr_ctrl) begin
            rise_q <= wdata_i[CTRL_RISE_BIT];
            both_q <= wdata_i[CTRL_BOTH_BIT];
        end
    end

    // Sticky flag: capture sets it (wins), a write of 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  flag_q <= 1'b0;
        else if (hit_i && !standby_i)                flag_q <= 1'b1;
        else if (wr_ctrl && !wdata_i[CTRL_FLAG_BIT]) flag_q <= 1'b0;
    end

    // Registered read port: samples pre-edge state, so collisions return old data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_req) begin
            if (addr_i == A_CAP)       rdata_q <= cap_q;
            else if (addr_i == A_CTRL) rdata_q <= ctrl_word;
            else                       rdata_q <= '0;
        end
    end

    assign rdata_o    = rdata_q;
    assign cap_o      = cap_q;
    assign rise_sel_o = rise_q;
    assign both_sel_o = both_q;
    assign flag_o     = flag_q;
endmodule

// File: rtl/icap_unit.sv
// Input capture unit top: synchroniser, edge qualifier and register file.
// Assumes cnt_i is synchronous to clk and cap_pin_i may be asynchronous.
module icap_unit
    import icap_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cap_pin_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              cap_flag_o
);
    logic             sync_cur;
    logic             sync_prev;
    logic             cap_hit;
    logic             rise_sel;
    logic             both_sel;
    logic [CNT_W-1:0] cap_val;
    edge_kind_t       edge_kind;

    // Map the mode bits onto an edge kind.
    always_comb edge_kind = decode_sel(rise_sel, both_sel);

    icap_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_pin_i),
        .cur_o  (sync_cur),
        .prev_o (sync_prev)
    );

    icap_edge_sel edge_i (
        .cur_i  (sync_cur),
        .prev_i (sync_prev),
        .kind_i (edge_kind),
        .hit_o  (cap_hit)
    );

    icap_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .cnt_i      (cnt_i),
        .hit_i      (cap_hit),
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .cap_o      (cap_val),
        .rise_sel_o (rise_sel),
        .both_sel_o (both_sel),
        .flag_o     (cap_flag_o)
    );
endmodule

// File: rtl/icap_unit_chk.sv
// Assertion checker for icap_unit, attached by bind below.
// Observes ports and internal nets between the submodules only.
module icap_unit_chk
    import icap_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_i,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [CNT_W-1:0]  bus_wdata_i,
    input logic              cap_flag_o,
    input logic [CNT_W-1:0]  cap_val,
    input logic              cap_hit,
    input logic              sync_cur,
    input logic              sync_prev,
    input logic              rise_sel,
    input logic              both_sel
);
    logic clr_wr;
    always_comb clr_wr = bus_sel_i && bus_wr_i &&
                         (bus_addr_i == ADDR_W'(ADDR_CTRL)) && !bus_wdata_i[CTRL_FLAG_BIT];

    // R6: the flag stays set unless a clearing write arrives.
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_o && !clr_wr) |=> cap_flag_o);

    // R5: a qualified event sets the flag at the next edge.
    p_flag_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hit && !standby_i) |=> cap_flag_o);

    // R8: standby empties the capture register.
    p_standby_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (cap_val == '0));

    // R5: the capture value only moves after an event or standby.
    p_cap_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_val != $past(cap_val)) |-> ($past(cap_hit) || $past(standby_i)));

    // R2: in falling mode an event is always a high-to-low transition.
    p_fall_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_sel && !both_sel && cap_hit) |-> (sync_prev && !sync_cur));

    // R3: with rise select set an event is always a low-to-high transition.
    p_rise_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_sel && cap_hit) |-> (sync_cur && !sync_prev));
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cap_flag_o  (cap_flag_o),
    .cap_val     (cap_val),
    .cap_hit     (cap_hit),
    .sync_cur    (sync_cur),
    .sync_prev   (sync_prev),
    .rise_sel    (rise_sel),
    .both_sel    (both_sel)
);

// File: tb/icap_unit_tb_top.sv
`timescale 1ns/1ps
module icap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_i = 1'b0;
    logic [15:0] cnt_i = 16'h1000;
    logic        cap_pin_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [1:0]  bus_addr_i = 2'd0;
    logic [15:0] bus_wdata_i = 16'h0;
    logic [15:0] bus_rdata_o;
    logic        cap_flag_o;

    int n_chk = 0;
    int n_bad = 0;
    logic        rd_seen = 1'b0;
    logic [15:0] q_val[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;   // 200 MHz

    icap_unit dut_i (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .cnt_i(cnt_i),
        .cap_pin_i(cap_pin_i), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .cap_flag_o(cap_flag_o)
    );

    // Free-running counter, advanced away from the active edge.
    always @(negedge clk) cnt_i <= cnt_i + 16'd1;

    // Note which posedges sampled a read request.
    always @(posedge clk) rd_seen <= bus_sel_i && !bus_wr_i && rst_n;

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: read data is due one edge after the request.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (q_val.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R7 actual=unexpected_read expected=none");
            end else begin
                logic [15:0] ev;
                string       et;
                ev = q_val.pop_front();
                et = q_tag.pop_front();
                check16(et, bus_rdata_o, ev);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Issue a read at the current negedge; the scoreboard gets the expectation.
    task automatic read_now(logic [1:0] a, logic [15:0] exp, string tag);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        q_val.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        bus_sel_i = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        read_now(a, exp, tag);
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    endtask

    // Change the pin; a capture would hold the counter three edges later.
    task automatic set_pin(logic v, output logic [15:0] exp);
        @(negedge clk);
        cap_pin_i = v;
        exp = cnt_i + 16'd3;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] e0, e1, e2, e3, e4, e5, e6, e7, dummy;
        tick(4);
        rst_n = 1'b1;

        // R1: reset values.
        tick(1);
        check16("R1 flag", {15'd0, cap_flag_o}, 16'd0);
        bus_read(2'd0, 16'h0000, "R1 cap");
        bus_read(2'd1, 16'h0000, "R1 ctrl");

        // R2: falling mode ignores a rising transition.
        set_pin(1'b1, dummy);
        tick(4);
        check16("R2 flag after rise", {15'd0, cap_flag_o}, 16'd0);
        bus_read(2'd0, 16'h0000, "R2 cap after rise");
        // R2/R5: falling transition captures with exact latency.
        set_pin(1'b0, e0);
        tick(2);
        check16("R5 flag early", {15'd0, cap_flag_o}, 16'd0);
        tick(1);
        check16("R5 flag set", {15'd0, cap_flag_o}, 16'd1);
        bus_read(2'd0, e0, "R2 R5 cap value");

        // R6: write 1 keeps flag, write 0 clears.
        bus_write(2'd1, 16'h0004);
        check16("R6 keep", {15'd0, cap_flag_o}, 16'd1);
        bus_write(2'd1, 16'h0000);
        check16("R6 clear", {15'd0, cap_flag_o}, 16'd0);
        bus_read(2'd1, 16'h0000, "R10 ctrl after clear");

        // R3: rise select with both select also set -> rising only.
        bus_write(2'd1, 16'h0003);
        bus_read(2'd1, 16'h0003, "R10 ctrl readback");
        set_pin(1'b1, e1);
        tick(4);
        check16("R3 flag rise", {15'd0, cap_flag_o}, 16'd1);
        bus_read(2'd0, e1, "R3 cap rise");
        bus_write(2'd1, 16'h0003);
        set_pin(1'b0, dummy);
        tick(4);
        check16("R3 flag fall ignored", {15'd0, cap_flag_o}, 16'd0);
        bus_read(2'd0, e1, "R3 cap fall ignored");

        // R9: rise-only mode, pulse two periods wide.
        bus_write(2'd1, 16'h0001);
        set_pin(1'b1, e2);
        tick(1);
        set_pin(1'b0, dummy);
        tick(4);
        bus_read(2'd0, e2, "R9 single-edge pulse");
        bus_read(2'd1, 16'h0005, "R10 ctrl with flag");

        // R4: both-edges mode, spaced transitions.
        bus_write(2'd1, 16'h0002);
        set_pin(1'b1, e3);
        tick(4);
        bus_read(2'd0, e3, "R4 rise capture");
        set_pin(1'b0, e4);
        tick(4);
        bus_read(2'd0, e4, "R4 fall capture");

        // R9: both-edges mode, pulse three periods wide gives two captures.
        set_pin(1'b1, e5);
        tick(2);
        set_pin(1'b0, e6);
        read_now(2'd0, e5, "R9 leading capture");
        tick(3);
        bus_read(2'd0, e6, "R9 trailing capture");

        // R7: read sampled at the capture edge returns the old value.
        set_pin(1'b1, e7);
        tick(1);
        bus_read(2'd0, e6, "R7 collision old value");
        bus_read(2'd0, e7, "R7 new value after");

        // R8: standby clears the capture register.
        @(negedge clk); standby_i = 1'b1;
        @(negedge clk); standby_i = 1'b0;
        bus_read(2'd0, 16'h0000, "R8 standby clear");

        tick(3);
        n_chk++;
        if (q_val.size() != 0) begin
            n_bad++;
            $display("FAIL R7 actual=%0d pending expected=0", q_val.size());
        end
        summary();
        $finish;
    end
endmodule